// File: doc/BRIEF.md
# Floating-Point Instruction Class Decoder

This block turns a 32-bit coprocessor floating-point instruction word into a decoded operation, a precision code and three register indices. It also raises an exception code whenever the combination of major opcode, class, sub-operation and format is not legal. A mode input selects between a legacy architecture level and an extended level. The two levels differ in how wide the conversion sub-operation field is and in how a compare is told apart from a test. The arithmetic, the register file and the trap handling sit outside this block.

Two major opcode groups are decoded. Group 0x0C names whole 64-bit registers. Group 0x0E names 32-bit halves, where an extra bit picks the left or right word. Every index leaves the block in 32-bit word units and is 7 bits wide. Index 64 stands for a constant-zero register that is read in place of register 0. The decode is captured on a valid strobe and appears one cycle later, together with a one-cycle done pulse.

Top module: `fp_insn_decoder`

## Requirements
- R1: When `valid_i` is high at a rising edge, that edge loads the decode into the outputs and raises `done_o` for exactly one cycle. Without the strobe, the outputs hold and `done_o` is low. Reset clears every output to zero.
- R2: The fields are: major [31:26], first source [25:21], second source [20:16], sub-operation [15:13], format [12:11], class [10:9] and target [4:0]. A legal operation reports `op_o` = {class, sub-operation} and, outside class 1, `prec_o` = format.
- R3: In class 1 the sub-operation is {0, [16:15]} in legacy mode (`ext_mode_i`=0) and [17:15] in extended mode. Sub-operation 4 is illegal.
- R4: Class 0 accepts sub-operations 2 to 7, and 0 or 1 are illegal. Class 3 accepts sub-operations 0 to 4, and 5 to 7 are illegal.
- R5: Format 2 is always illegal. Format 3 (quad) is legal only in group 0x0C, and there only for sub-operations 2, 3, 6 and 7 of class 0. For those, bit 0 of the first source and target fields is cleared.
- R6: In class 1 the destination format is [14:13]. If bit 1 of either format is set, the instruction is illegal. Otherwise `prec_o` = {format[0], destination[0]}, and sub-operation 0 rejects the codes 0 and 3.
- R7: In group 0x0C an index is {field, 0}. The second source is used only in classes 2 and 3, and an unused index reads 0.
- R8: In group 0x0E an index is {field, half}, with the half bits at [7] for the first source, [12] for the second source and [6] for the target. Classes 2 and 3 take their format from bit [11] alone. When the format is 1 (double), both sources are forced even. The target is forced even as well, except in class 1, where it is forced even only when the destination format is 1.
- R9: A source index that is 0 after alignment reads as 64.
- R10: A target index that is 0 after alignment is illegal, except in class 2. There `dst_o` carries the raw condition field [4:0].
- R11: Class 2 selects between two forms. In extended mode, bit [5] set gives test and clear gives compare. In legacy mode, sub-operation 0 is compare, 1 is test, and 2 to 7 are illegal. Compare reports `op_o`=16 and is illegal with format 2 or 3. Test reports `op_o`=17 with every other output zero, and is legal only in group 0x0C with format 0.
- R12: An illegal instruction gives `exc_o` = 0x09 in group 0x0C and 0x0B in group 0x0E. Any other major opcode gives 0x01. A legal decode gives 0. `illegal_o` is high exactly when `exc_o` is non-zero.
- R13: The exact word 0x30000000 is a version query. It reports `op_o`=1 with every other output zero.
- R14: While `illegal_o` is high, `op_o`, `prec_o`, `src1_o`, `src2_o` and `dst_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for `insn_i` |
| insn_i | input | 32 | Instruction word |
| ext_mode_i | input | 1 | 1 selects the extended architecture level |
| done_o | output | 1 | One-cycle pulse after a capture |
| op_o | output | 5 | Operation code |
| prec_o | output | 2 | Precision code |
| src1_o | output | 7 | First source word index |
| src2_o | output | 7 | Second source word index |
| dst_o | output | 7 | Target word index or compare condition |
| illegal_o | output | 1 | Instruction rejected |
| exc_o | output | 8 | Exception code |

## Verification
On every cycle, the assertions check the capture and hold timing and the zeroing of the outputs on a reject. They also check that an illegal flag always comes with a non-zero exception code, that a legal arithmetic operation never names register 0 as a source, and that a legal non-compare operation never names it as a target. Only the bench scenarios show the field positions themselves. That covers the mode-dependent width of the conversion sub-operation, the half-word alignment in group 0x0E, the quad-only operations and the split between compare and test, which the bench checks against its own decode of random and directed words.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int unsigned INSN_W  = 32;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned IDX_W   = FIELD_W + 2;
  localparam int unsigned OP_W    = 5;
  localparam int unsigned EXC_W   = 8;
  localparam int unsigned N_OPND  = 3;

  localparam logic [IDX_W-1:0]  ZERO_IDX     = IDX_W'(1) << (FIELD_W + 1);
  localparam logic [5:0]        GRP_WHOLE    = 6'h0C;
  localparam logic [5:0]        GRP_HALF     = 6'h0E;
  localparam logic [EXC_W-1:0]  EXC_WHOLE    = 8'h09;
  localparam logic [EXC_W-1:0]  EXC_HALF     = 8'h0B;
  localparam logic [EXC_W-1:0]  EXC_UNSUP    = 8'h01;
  localparam logic [INSN_W-1:0] VERSION_WORD = 32'h3000_0000;
  localparam logic [OP_W-1:0]   OP_VERSION   = 5'd1;
  localparam logic [OP_W-1:0]   OP_CMP       = 5'd16;
  localparam logic [OP_W-1:0]   OP_TEST      = 5'd17;

  typedef struct packed {
    logic [5:0]         major;
    logic [1:0]         cls;
    logic [2:0]         subop;
    logic [1:0]         fmt;
    logic [1:0]         dfmt;
    logic [FIELD_W-1:0] r1;
    logic [FIELD_W-1:0] r2;
    logic [FIELD_W-1:0] t;
    logic               h1;
    logic               h2;
    logic               ht;
    logic               test_bit;
  } fields_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic [1:0]      prec;
    logic            illegal;
    logic            use_s1;
    logic            use_s2;
    logic            use_dst;
    logic            cmp_dst;
    logic            even_s1;
    logic            even_s2;
    logic            even_dst;
    logic            quad;
  } ctl_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [1:0]       prec;
    logic [IDX_W-1:0] src1;
    logic [IDX_W-1:0] src2;
    logic [IDX_W-1:0] dst;
    logic             illegal;
    logic [EXC_W-1:0] exc;
  } dec_t;
endpackage

// File: rtl/fpd_fields.sv
module fpd_fields
  import fpd_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  input  logic              ext_mode_i,
  output fields_t           fld_o,
  output logic              grp_half_o,
  output logic              grp_ok_o,
  output logic              version_o
);
  logic [5:0] major;
  logic [1:0] cls;

  assign major = insn_i[31:26];
  assign cls   = insn_i[10:9];

  always_comb begin
    fld_o.major = major;
    fld_o.cls   = cls;
    // conversion sub-operation width follows the architecture level
    if (cls == 2'd1) fld_o.subop = ext_mode_i ? insn_i[17:15] : {1'b0, insn_i[16:15]};
    else             fld_o.subop = insn_i[15:13];
    // half-register group: classes 2/3 carry a one-bit format
    if (major == GRP_HALF && cls[1]) fld_o.fmt = {1'b0, insn_i[11]};
    else                             fld_o.fmt = insn_i[12:11];
    fld_o.dfmt     = insn_i[14:13];
    fld_o.r1       = insn_i[25:21];
    fld_o.r2       = insn_i[20:16];
    fld_o.t        = insn_i[4:0];
    fld_o.h1       = insn_i[7];
    fld_o.h2       = insn_i[12];
    fld_o.ht       = insn_i[6];
    fld_o.test_bit = insn_i[5];
  end

  assign grp_half_o = (major == GRP_HALF);
  assign grp_ok_o   = (major == GRP_WHOLE) || grp_half_o;
  assign version_o  = (insn_i == VERSION_WORD);
endmodule

// File: rtl/fpd_classify.sv
module fpd_classify
  import fpd_pkg::*;
(
  input  fields_t fld_i,
  input  logic    grp_half_i,
  input  logic    ext_mode_i,
  output ctl_t    ctl_o
);
  logic dbl;
  logic is_test;

  assign dbl = (fld_i.fmt == 2'd1);

  always_comb begin
    ctl_o          = '0;
    ctl_o.op       = {fld_i.cls, fld_i.subop};
    ctl_o.prec     = fld_i.fmt;
    ctl_o.use_s1   = 1'b1;
    ctl_o.use_dst  = 1'b1;
    ctl_o.even_s1  = grp_half_i && dbl;
    ctl_o.even_s2  = grp_half_i && dbl;
    ctl_o.even_dst = grp_half_i && dbl;
    is_test        = 1'b0;
    unique case (fld_i.cls)
      2'd0: begin
        if (fld_i.subop < 3'd2)        ctl_o.illegal = 1'b1;
        else if (fld_i.fmt == 2'd2)    ctl_o.illegal = 1'b1;
        else if (fld_i.fmt == 2'd3) begin
          if (grp_half_i || fld_i.subop == 3'd4 || fld_i.subop == 3'd5)
            ctl_o.illegal = 1'b1;
          else
            ctl_o.quad = 1'b1;
        end
      end
      2'd1: begin
        ctl_o.even_dst = grp_half_i && (fld_i.dfmt == 2'd1);
        ctl_o.prec     = {fld_i.fmt[0], fld_i.dfmt[0]};
        if (fld_i.fmt[1] || fld_i.dfmt[1])  ctl_o.illegal = 1'b1;
        else if (fld_i.subop == 3'd4)       ctl_o.illegal = 1'b1;
        else if (fld_i.subop == 3'd0 && (fld_i.fmt[0] == fld_i.dfmt[0]))
          ctl_o.illegal = 1'b1;
      end
      2'd2: begin
        ctl_o.use_dst = 1'b0;
        is_test = ext_mode_i ? fld_i.test_bit : (fld_i.subop == 3'd1);
        if (!ext_mode_i && fld_i.subop > 3'd1) begin
          ctl_o.illegal = 1'b1;
        end else if (is_test) begin
          ctl_o.op     = OP_TEST;
          ctl_o.use_s1 = 1'b0;
          if (grp_half_i || fld_i.fmt != 2'd0) ctl_o.illegal = 1'b1;
        end else begin
          ctl_o.op      = OP_CMP;
          ctl_o.use_s2  = 1'b1;
          ctl_o.cmp_dst = 1'b1;
          if (fld_i.fmt[1]) ctl_o.illegal = 1'b1;
        end
      end
      default: begin
        ctl_o.use_s2 = 1'b1;
        if (fld_i.subop > 3'd4 || fld_i.fmt[1]) ctl_o.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fpd_index.sv
module fpd_index
  import fpd_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               half_i,
  input  logic               grp_half_i,
  input  logic               even_word_i,
  input  logic               even_reg_i,
  input  logic               remap_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               raw_zero_o
);
  logic [FIELD_W-1:0] f;
  logic               w;
  logic [IDX_W-1:0]   raw;

  always_comb begin
    f = field_i;
    if (even_reg_i) f[0] = 1'b0;
    w = grp_half_i ? half_i : 1'b0;
    if (even_word_i) w = 1'b0;
    raw = {1'b0, f, w};
  end

  assign raw_zero_o = (raw == '0);
  assign idx_o      = (remap_i && raw_zero_o) ? ZERO_IDX : raw;
endmodule

// File: rtl/fp_insn_decoder.sv
module fp_insn_decoder
  import fpd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              ext_mode_i,
  output logic              done_o,
  output logic [OP_W-1:0]   op_o,
  output logic [1:0]        prec_o,
  output logic [IDX_W-1:0]  src1_o,
  output logic [IDX_W-1:0]  src2_o,
  output logic [IDX_W-1:0]  dst_o,
  output logic              illegal_o,
  output logic [EXC_W-1:0]  exc_o
);
  fields_t fld;
  ctl_t    ctl;
  logic    grp_half, grp_ok, is_version;
  dec_t    dec_d, dec_q;

  logic [FIELD_W-1:0] opnd_field [N_OPND];
  logic               opnd_half  [N_OPND];
  logic               opnd_evw   [N_OPND];
  logic               opnd_evr   [N_OPND];
  logic               opnd_remap [N_OPND];
  logic [IDX_W-1:0]   opnd_idx   [N_OPND];
  logic               opnd_zero  [N_OPND];

  fpd_fields u_fields (
    .insn_i     (insn_i),
    .ext_mode_i (ext_mode_i),
    .fld_o      (fld),
    .grp_half_o (grp_half),
    .grp_ok_o   (grp_ok),
    .version_o  (is_version)
  );

  fpd_classify u_classify (
    .fld_i      (fld),
    .grp_half_i (grp_half),
    .ext_mode_i (ext_mode_i),
    .ctl_o      (ctl)
  );

  // operand order: 0 first source, 1 second source, 2 target
  always_comb begin
    opnd_field[0] = fld.r1;  opnd_half[0] = fld.h1;
    opnd_field[1] = fld.r2;  opnd_half[1] = fld.h2;
    opnd_field[2] = fld.t;   opnd_half[2] = fld.ht;
    opnd_evw[0]   = ctl.even_s1;
    opnd_evw[1]   = ctl.even_s2;
    opnd_evw[2]   = ctl.even_dst;
    opnd_evr[0]   = ctl.quad;
    opnd_evr[1]   = 1'b0;
    opnd_evr[2]   = ctl.quad;
    opnd_remap[0] = 1'b1;
    opnd_remap[1] = 1'b1;
    opnd_remap[2] = 1'b0;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fpd_index u_index (
      .field_i     (opnd_field[g]),
      .half_i      (opnd_half[g]),
      .grp_half_i  (grp_half),
      .even_word_i (opnd_evw[g]),
      .even_reg_i  (opnd_evr[g]),
      .remap_i     (opnd_remap[g]),
      .idx_o       (opnd_idx[g]),
      .raw_zero_o  (opnd_zero[g])
    );
  end

  logic reject;
  assign reject = ctl.illegal || (ctl.use_dst && opnd_zero[2]);

  always_comb begin
    dec_d = '0;
    if (is_version) begin
      dec_d.op = OP_VERSION;
    end else if (!grp_ok) begin
      dec_d.illegal = 1'b1;
      dec_d.exc     = EXC_UNSUP;
    end else if (reject) begin
      dec_d.illegal = 1'b1;
      dec_d.exc     = grp_half ? EXC_HALF : EXC_WHOLE;
    end else begin
      dec_d.op   = ctl.op;
      dec_d.prec = ctl.prec;
      dec_d.src1 = ctl.use_s1 ? opnd_idx[0] : '0;
      dec_d.src2 = ctl.use_s2 ? opnd_idx[1] : '0;
      if (ctl.use_dst)      dec_d.dst = opnd_idx[2];
      else if (ctl.cmp_dst) dec_d.dst = IDX_W'(fld.t);
    end
  end

  if (REG_OUT) begin : g_reg
    logic done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dec_q  <= '0;
        done_q <= 1'b0;
      end else begin
        done_q <= valid_i;
        if (valid_i) dec_q <= dec_d;
      end
    end
    assign done_o = done_q;
  end else begin : g_comb
    assign dec_q  = dec_d;
    assign done_o = valid_i;
  end

  assign op_o      = dec_q.op;
  assign prec_o    = dec_q.prec;
  assign src1_o    = dec_q.src1;
  assign src2_o    = dec_q.src2;
  assign dst_o     = dec_q.dst;
  assign illegal_o = dec_q.illegal;
  assign exc_o     = dec_q.exc;
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker
  import fpd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             done_o,
  input logic [OP_W-1:0]  op_o,
  input logic [1:0]       prec_o,
  input logic [IDX_W-1:0] src1_o,
  input logic [IDX_W-1:0] src2_o,
  input logic [IDX_W-1:0] dst_o,
  input logic             illegal_o,
  input logic [EXC_W-1:0] exc_o
);
  // R14
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (op_o == '0 && prec_o == '0 && src1_o == '0 && src2_o == '0 && dst_o == '0));

  // R12
  exc_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o == (exc_o != '0));

  // R9
  src_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && op_o[4:3] == 2'b11) |-> (src1_o != '0 && src2_o != '0));

  // R10
  dst_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && op_o[4:3] != 2'b10 && op_o != OP_VERSION) |-> (dst_o != '0));

  if (REG_OUT) begin : g_seq
    // R1
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(valid_i));

    // R1
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!done_o && $stable(op_o) && $stable(src1_o) && $stable(src2_o)
                    && $stable(dst_o) && $stable(exc_o)));
  end
endmodule

bind fp_insn_decoder fpd_checker #(.REG_OUT(REG_OUT)) u_fpd_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .done_o    (done_o),
  .op_o      (op_o),
  .prec_o    (prec_o),
  .src1_o    (src1_o),
  .src2_o    (src2_o),
  .dst_o     (dst_o),
  .illegal_o (illegal_o),
  .exc_o     (exc_o)
);

// File: tb/fp_insn_decoder_tb.sv
`timescale 1ns/1ps
module fp_insn_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        ext_mode_i = 1'b0;
  logic        done_o;
  logic [4:0]  op_o;
  logic [1:0]  prec_o;
  logic [6:0]  src1_o, src2_o, dst_o;
  logic        illegal_o;
  logic [7:0]  exc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  fp_insn_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .ext_mode_i(ext_mode_i), .done_o(done_o), .op_o(op_o), .prec_o(prec_o),
    .src1_o(src1_o), .src2_o(src2_o), .dst_o(dst_o), .illegal_o(illegal_o),
    .exc_o(exc_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] a,
                                     input logic [4:0] b, input logic [2:0] so,
                                     input logic [1:0] fm, input logic [1:0] cl,
                                     input logic [3:0] mid, input logic [4:0] t);
    return {maj, a, b, so, fm, cl, mid, t};
  endfunction

  function automatic logic [36:0] bad(input logic [7:0] code);
    return {28'd0, 1'b1, code};
  endfunction

  // expected {op, prec, src1, src2, dst, illegal, exc}
  function automatic logic [36:0] ref_decode(input logic [31:0] w, input logic m);
    logic [5:0] maj;
    logic [1:0] cl, fm, dfm, pr;
    logic [2:0] so;
    logic [4:0] op, f;
    logic       grpb, dbl, quad, u1, u2, ud, cd, rej, tst, h;
    logic [6:0] s1, s2, d;
    maj = w[31:26];
    cl  = w[10:9];
    if (w == 32'h3000_0000) return {5'd1, 32'd0};
    if (maj != 6'h0C && maj != 6'h0E) return bad(8'h01);
    grpb = (maj == 6'h0E);
    so   = (cl == 2'd1) ? (m ? w[17:15] : {1'b0, w[16:15]}) : w[15:13];
    fm   = (grpb && cl >= 2'd2) ? {1'b0, w[11]} : w[12:11];
    dfm  = w[14:13];
    dbl  = grpb && (fm == 2'd1);
    op = {cl, so}; pr = fm; u1 = 1; u2 = 0; ud = 1; cd = 0; rej = 0; quad = 0;
    case (cl)
      2'd0: begin
        if (so < 2 || fm == 2) rej = 1;
        else if (fm == 3) begin
          if (grpb || so == 4 || so == 5) rej = 1; else quad = 1;
        end
      end
      2'd1: begin
        pr = {fm[0], dfm[0]};
        if (fm[1] || dfm[1] || so == 4) rej = 1;
        else if (so == 0 && fm[0] == dfm[0]) rej = 1;
      end
      2'd2: begin
        ud = 0;
        tst = m ? w[5] : (so == 1);
        if (!m && so > 1) rej = 1;
        else if (tst) begin
          op = 5'd17; u1 = 0;
          if (grpb || fm != 0) rej = 1;
        end else begin
          op = 5'd16; u2 = 1; cd = 1;
          if (fm[1]) rej = 1;
        end
      end
      default: begin
        u2 = 1;
        if (so > 4 || fm[1]) rej = 1;
      end
    endcase
    f = w[25:21]; if (quad) f[0] = 0;
    h = grpb ? w[7] : 1'b0; if (dbl) h = 0;
    s1 = {1'b0, f, h}; if (s1 == 0) s1 = 7'd64;
    h = grpb ? w[12] : 1'b0; if (dbl) h = 0;
    s2 = {1'b0, w[20:16], h}; if (s2 == 0) s2 = 7'd64;
    f = w[4:0]; if (quad) f[0] = 0;
    h = grpb ? w[6] : 1'b0;
    if (grpb && ((cl == 2'd1) ? (dfm == 2'd1) : (fm == 2'd1))) h = 0;
    d = {1'b0, f, h};
    if (ud && d == 0) rej = 1;
    if (rej) return bad(grpb ? 8'h0B : 8'h09);
    return {op, pr, u1 ? s1 : 7'd0, u2 ? s2 : 7'd0,
            ud ? d : (cd ? {2'b0, w[4:0]} : 7'd0), 1'b0, 8'h00};
  endfunction

  function automatic logic [36:0] got_vec();
    return {op_o, prec_o, src1_o, src2_o, dst_o, illegal_o, exc_o};
  endfunction

  task automatic apply_exp(input logic [31:0] w, input logic m,
                           input logic [36:0] exp, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; insn_i = w; ext_mode_i = m;
    @(negedge clk_i);
    valid_i = 1'b0;
    checks++;
    if (done_o !== 1'b1 || got_vec() !== exp) begin
      errors++;
      $display("FAIL %s insn=%h mode=%0d got=%h done=%b exp=%h done=1",
               tag, w, m, got_vec(), done_o, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic m, input string tag);
    apply_exp(w, m, ref_decode(w, m), tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, got=timeout exp=finish");
    if (!finished) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [36:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    checks++;
    if (done_o !== 1'b0 || got_vec() !== 37'd0) begin
      errors++;
      $display("FAIL R1 reset got=%h done=%b exp=0 done=0", got_vec(), done_o);
    end
    rst_ni = 1'b1;

    // R13 version query
    apply_exp(32'h3000_0000, 1'b0, {5'd1, 32'd0}, "R13 version");
    // R12 unsupported major
    apply_exp(mk(6'h06, 3, 4, 0, 1, 3, 0, 5), 1'b0, bad(8'h01), "R12 unsupported major");
    // R2 R7 R9 add double, second source remapped
    apply_exp(mk(6'h0C, 3, 0, 0, 1, 3, 0, 5), 1'b0,
              {5'd24, 2'd1, 7'd6, 7'd64, 7'd10, 1'b0, 8'd0}, "R2 R7 R9 add");
    // R10 target zero rejected
    apply_exp(mk(6'h0C, 3, 4, 0, 1, 3, 0, 0), 1'b0, bad(8'h09), "R10 target zero");
    // R10 compare with condition 0 is legal
    apply_exp(mk(6'h0C, 2, 3, 0, 0, 2, 0, 0), 1'b0,
              {5'd16, 2'd0, 7'd4, 7'd6, 7'd0, 1'b0, 8'd0}, "R10 R11 compare");
    // R8 half group copy double forces even
    apply_exp(mk(6'h0E, 3, 0, 2, 1, 0, 4'b0110, 4), 1'b0,
              {5'd2, 2'd1, 7'd6, 7'd0, 7'd8, 1'b0, 8'd0}, "R8 copy double");
    apply_exp(mk(6'h0E, 3, 0, 2, 0, 0, 4'b0110, 4), 1'b0,
              {5'd2, 2'd0, 7'd7, 7'd0, 7'd9, 1'b0, 8'd0}, "R8 copy single");
    // R8 R6 conversion single to double: target even, source keeps half
    apply_exp(mk(6'h0E, 3, 0, 3'b001, 0, 1, 4'b0110, 4), 1'b0,
              {5'd8, 2'd1, 7'd7, 7'd0, 7'd8, 1'b0, 8'd0}, "R8 R6 convert");
    // R3 sub-operation width by mode
    apply_exp(mk(6'h0C, 3, 5'd2, 3'b100, 0, 1, 0, 5), 1'b0,
              {5'd9, 2'd0, 7'd6, 7'd0, 7'd10, 1'b0, 8'd0}, "R3 legacy subop");
    apply_exp(mk(6'h0C, 3, 5'd2, 3'b100, 0, 1, 0, 5), 1'b1,
              {5'd13, 2'd0, 7'd6, 7'd0, 7'd10, 1'b0, 8'd0}, "R3 extended subop");
    apply_exp(mk(6'h0C, 3, 5'd2, 3'b001, 0, 1, 0, 5), 1'b0,
              {5'd8, 2'd1, 7'd6, 7'd0, 7'd10, 1'b0, 8'd0}, "R3 legacy conversion");
    apply_exp(mk(6'h0C, 3, 5'd2, 3'b001, 0, 1, 0, 5), 1'b1, bad(8'h09), "R3 subop 4");
    // R6 format bit 1 and same-precision float conversion
    apply_exp(mk(6'h0C, 3, 0, 3'b001, 2, 1, 0, 5), 1'b0, bad(8'h09), "R6 format bit1");
    apply_exp(mk(6'h0C, 3, 0, 3'b000, 0, 1, 0, 5), 1'b0, bad(8'h09), "R6 code 0");
    // R5 quad rules
    apply_exp(mk(6'h0C, 3, 0, 2, 3, 0, 0, 5), 1'b0,
              {5'd2, 2'd3, 7'd4, 7'd0, 7'd8, 1'b0, 8'd0}, "R5 quad copy");
    apply_exp(mk(6'h0C, 3, 0, 4, 3, 0, 0, 5), 1'b0, bad(8'h09), "R5 quad sqrt");
    apply_exp(mk(6'h0C, 3, 0, 3, 2, 0, 0, 5), 1'b0, bad(8'h09), "R5 format 2");
    apply_exp(mk(6'h0E, 3, 0, 2, 3, 0, 0, 5), 1'b0, bad(8'h0B), "R5 quad half group");
    // R11 compare and test forms
    apply_exp(mk(6'h0C, 3, 4, 0, 0, 2, 4'b0001, 7), 1'b1, {5'd17, 32'd0}, "R11 test");
    apply_exp(mk(6'h0C, 3, 4, 3, 1, 2, 4'b0000, 7), 1'b1,
              {5'd16, 2'd1, 7'd6, 7'd8, 7'd7, 1'b0, 8'd0}, "R11 extended compare");
    apply_exp(mk(6'h0C, 3, 4, 2, 0, 2, 0, 7), 1'b0, bad(8'h09), "R11 legacy subop 2");
    apply_exp(mk(6'h0E, 3, 4, 0, 0, 2, 4'b0001, 7), 1'b1, bad(8'h0B), "R11 test half group");
    // R4 class 0 and class 3 limits
    apply_exp(mk(6'h0C, 3, 0, 1, 0, 0, 0, 5), 1'b0, bad(8'h09), "R4 class0 subop1");
    apply_exp(mk(6'h0C, 3, 4, 5, 0, 3, 0, 5), 1'b0, bad(8'h09), "R4 class3 subop5");
    apply_exp(mk(6'h0C, 3, 4, 4, 0, 3, 0, 5), 1'b0,
              {5'd28, 2'd0, 7'd6, 7'd8, 7'd10, 1'b0, 8'd0}, "R4 remainder");
    // R9 R8 aligned source becomes zero register
    apply_exp(mk(6'h0E, 0, 0, 0, 2'b01, 3, 4'b0100, 2), 1'b0,
              {5'd24, 2'd1, 7'd64, 7'd64, 7'd4, 1'b0, 8'd0}, "R9 R8 aligned zero");
    // R14 R12 rejection clears fields
    apply_exp(mk(6'h0E, 3, 4, 6, 0, 3, 0, 5), 1'b0, bad(8'h0B), "R14 R12 half reject");

    // R1 hold without strobe
    held = got_vec();
    @(negedge clk_i);
    insn_i = 32'h3000_0000; ext_mode_i = 1'b1;
    repeat (2) @(negedge clk_i);
    checks++;
    if (done_o !== 1'b0 || got_vec() !== held) begin
      errors++;
      $display("FAIL R1 hold got=%h done=%b exp=%h done=0", got_vec(), done_o, held);
    end

    // R2 R14 random words against the bench decode
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      int sel;
      w   = $urandom;
      sel = $urandom_range(0, 9);
      if (sel < 4)      w[31:26] = 6'h0C;
      else if (sel < 8) w[31:26] = 6'h0E;
      apply(w, 1'(($urandom) & 1), "R2 R14 random");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule